// File: doc/BRIEF.md
# Stereo Audio Serial Transmit Port

This block sends stereo audio from two sample registers, one for the left channel and one for the right. Each sample goes out one bit at a time on a serial data line, together with a bit clock and a word strobe. In master mode the block makes the bit clock and the word strobe itself from an 8-bit divisor. In slave mode it tracks a word strobe that comes in from outside. It raises a one-cycle interrupt pulse on strobe transitions, and a mode register chooses which transitions count.

Software writes the two sample registers, the divisor and the mode word over a simple register bus. It reads back the strobe state from a status word at the divisor's offset. A write to the divisor resets the frame timing at once. This gives software a known phase when it starts a stream. In master mode a frame lasts 64*(divisor+1) system clocks, so the interrupt period is that long when one strobe direction is selected. A sample written during a frame goes out from the start of the next frame.

Top module: `audio_serial_port`

## Requirements
- R1: After reset the divisor is 8 and the block is in slave mode with every mode bit clear. All outputs are low. A read at offset 0x50 returns 0x0002 (strobe low, left channel).
- R2: Mode bit 0 set selects master mode. Then `sclk_o` spends (divisor+1) system clocks low and (divisor+1) high, starting low at the start of a frame. In slave mode `sclk_o` stays low.
- R3: A frame is 32 bit clocks long. It carries the left sample (offset 0x4C) and then the right sample (offset 0x48), each 16 bits with the MSB first. `sdata_o` changes only when `sclk_o` falls. Both samples are captured when a frame starts, so a write during a frame takes effect from the next frame.
- R4: In master mode the internal strobe is high during bit slots 15 through 30 of the frame and low for slot 31 and slots 0 to 14. It therefore changes one bit before each word's MSB. `ws_o` shows the strobe only while mode bit 2 is set.
- R5: A write to offset 0x50 loads the divisor from data bits 7:0. It also restarts the frame: phase returns to slot 0 with the clock low, and both samples are recaptured.
- R6: With mode bit 3 set, a pulse is raised each time the strobe rises. In master mode this gives one pulse every 64*(divisor+1) system clocks.
- R7: With mode bit 4 set, a pulse is raised each time the strobe falls. With mode bit 5 set, a pulse is raised at the start of every word: in master mode at slots 0 and 16, and in slave mode at any strobe change.
- R8: `irq_o` is high for exactly one system clock per event cycle. When several selected conditions hit in the same cycle, they give a single pulse.
- R9: In slave mode the strobe level equals `ws_i` as it was two clocks earlier (one synchronising stage, then one strobe stage).
- R10: A read at offset 0x50 returns the strobe level in bit 0 and its inverse (left channel) in bit 1, with every other bit zero. Reads at any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Status read data (combinational) |
| ws_i | input | 1 | External word strobe used in slave mode |
| sclk_o | output | 1 | Bit clock (master mode) |
| ws_o | output | 1 | Word strobe, gated by mode bit 2 |
| sdata_o | output | 1 | Serial data, MSB first |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `ws_i` holds each level for at least two system clocks. Without that, slave-mode strobe events could fall in adjacent cycles and break the single-pulse property. They also assume that only one register write happens per cycle. The stimulus toggles `ws_i` only every seven clocks and writes registers one at a time. It lets the strobe settle after each mode switch before it counts pulses.

// File: rtl/asp_pkg.sv
package asp_pkg;
    localparam logic [7:0] OFS_RIGHT = 8'h48;
    localparam logic [7:0] OFS_LEFT  = 8'h4C;
    localparam logic [7:0] OFS_DIV   = 8'h50;
    localparam logic [7:0] OFS_MODE  = 8'h54;

    localparam int MB_MASTER = 0;
    localparam int MB_WS_EN  = 2;
    localparam int MB_RISE   = 3;
    localparam int MB_FALL   = 4;
    localparam int MB_WORD   = 5;

    typedef struct packed {
        logic master;
        logic ws_en;
        logic on_rise;
        logic on_fall;
        logic on_word;
    } mode_t;
endpackage

// File: rtl/asp_bit_timer.sv
module asp_bit_timer #(
    parameter int DIV_W = 8,
    parameter int PH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic [PH_W-1:0]  ph_q,
    output logic [PH_W-1:0]  ph_d,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [PH_W-1:0]  ph;
    } tmr_t;

    tmr_t cur_q, nxt_d;
    logic hit;

    always_comb begin
        nxt_d = cur_q;
        hit   = run && (cur_q.pre == div);
        if (restart) begin
            nxt_d = '0;
        end else if (run) begin
            if (hit) begin
                nxt_d.pre = '0;
                nxt_d.ph  = cur_q.ph + 1'b1;
            end else begin
                nxt_d.pre = cur_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ph_q = cur_q.ph;
    assign ph_d = nxt_d.ph;
    assign tick = hit && !restart;
endmodule

// File: rtl/asp_frame_shifter.sv
module asp_frame_shifter #(
    parameter int FRAME_W = 32,
    parameter int PH_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               tick,
    input  logic [PH_W-1:0]    ph_q,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               sdata
);
    logic [FRAME_W-1:0] sh_q, sh_d;
    logic load, shift;

    always_comb begin
        load  = restart || (tick && (ph_q == '1));
        shift = tick && ph_q[0];
        sh_d  = sh_q;
        if (load)       sh_d = frame_in;
        else if (shift) sh_d = {sh_q[FRAME_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sdata = sh_q[FRAME_W-1];
endmodule

// File: rtl/asp_strobe_irq.sv
module asp_strobe_irq #(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master,
    input  logic            sel_rise,
    input  logic            sel_fall,
    input  logic            sel_word,
    input  logic            ws_ext,
    input  logic            tick,
    input  logic [PH_W-1:0] ph_d,
    output logic            ws_q,
    output logic            irq_q
);
    localparam int SLOT_W = 1 << (PH_W - 2);
    localparam logic [PH_W-2:0] HI_FIRST = (PH_W-1)'(SLOT_W - 1);
    localparam logic [PH_W-2:0] HI_LAST  = (PH_W-1)'(2 * SLOT_W - 2);

    typedef struct packed {
        logic sync;
        logic ws;
        logic irq;
    } st_t;

    st_t s_q, s_d;
    logic [PH_W-2:0] slot_idx;
    logic ws_int, ev_rise, ev_fall, ev_word;

    always_comb begin
        slot_idx = ph_d[PH_W-1:1];
        ws_int   = (slot_idx >= HI_FIRST) && (slot_idx <= HI_LAST);
        s_d.sync = ws_ext;
        s_d.ws   = master ? ws_int : s_q.sync;
        ev_rise  = s_d.ws && !s_q.ws;
        ev_fall  = !s_d.ws && s_q.ws;
        ev_word  = master ? (tick && (ph_d[PH_W-2:0] == '0)) : (s_d.ws != s_q.ws);
        s_d.irq  = (ev_rise && sel_rise) || (ev_fall && sel_fall) || (ev_word && sel_word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ws_q  = s_q.ws;
    assign irq_q = s_q.irq;
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
    parameter int SLOT_W    = 16,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [SLOT_W-1:0] reg_wdata,
    output logic [SLOT_W-1:0] reg_rdata,
    input  logic              ws_i,
    output logic              sclk_o,
    output logic              ws_o,
    output logic              sdata_o,
    output logic              irq_o
);
    import asp_pkg::*;

    localparam int FRAME_W = 2 * SLOT_W;
    localparam int PH_W    = $clog2(4 * SLOT_W);

    typedef struct packed {
        logic [SLOT_W-1:0] left;
        logic [SLOT_W-1:0] right;
        logic [DIV_W-1:0]  div;
        mode_t             mode;
    } regs_t;

    regs_t regs_q, regs_d;
    logic restart;
    logic [PH_W-1:0] ph_q, ph_d;
    logic tick, ws_lvl;
    logic master_q, ws_en_q, word_q;

    always_comb begin
        regs_d  = regs_q;
        restart = reg_wr && (reg_addr == OFS_DIV);
        if (reg_wr) begin
            unique case (reg_addr)
                OFS_LEFT:  regs_d.left  = reg_wdata;
                OFS_RIGHT: regs_d.right = reg_wdata;
                OFS_DIV:   regs_d.div   = reg_wdata[DIV_W-1:0];
                OFS_MODE: begin
                    regs_d.mode.master  = reg_wdata[MB_MASTER];
                    regs_d.mode.ws_en   = reg_wdata[MB_WS_EN];
                    regs_d.mode.on_rise = reg_wdata[MB_RISE];
                    regs_d.mode.on_fall = reg_wdata[MB_FALL];
                    regs_d.mode.on_word = reg_wdata[MB_WORD];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.div <= DIV_W'(DIV_RESET);
        end else begin
            regs_q <= regs_d;
        end
    end

    asp_bit_timer #(.DIV_W(DIV_W), .PH_W(PH_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(regs_q.mode.master), .restart(restart),
        .div(regs_q.div), .ph_q(ph_q), .ph_d(ph_d), .tick(tick)
    );

    asp_frame_shifter #(.FRAME_W(FRAME_W), .PH_W(PH_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .ph_q(ph_q),
        .frame_in({regs_q.left, regs_q.right}), .sdata(sdata_o)
    );

    asp_strobe_irq #(.PH_W(PH_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .master(regs_q.mode.master),
        .sel_rise(regs_q.mode.on_rise), .sel_fall(regs_q.mode.on_fall),
        .sel_word(regs_q.mode.on_word), .ws_ext(ws_i), .tick(tick), .ph_d(ph_d),
        .ws_q(ws_lvl), .irq_q(irq_o)
    );

    assign master_q  = regs_q.mode.master;
    assign ws_en_q   = regs_q.mode.ws_en;
    assign word_q    = regs_q.mode.on_word;
    assign sclk_o    = master_q && ph_q[0];
    assign ws_o      = ws_en_q && ws_lvl;
    assign reg_rdata = (reg_addr == OFS_DIV) ? {{(SLOT_W-2){1'b0}}, ~ws_lvl, ws_lvl} : '0;
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [15:0] reg_rdata,
    input logic        ws_i,
    input logic        sclk_o,
    input logic        ws_o,
    input logic        sdata_o,
    input logic        irq_o,
    input logic        master_q,
    input logic        ws_en_q,
    input logic        word_q,
    input logic        ws_lvl
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end

    p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_restart_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h50 && master_q) |=> (!sclk_o && !ws_lvl));

    p_status_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h50 && ws_en_q) |-> (reg_rdata[0] == ws_o));

    p_slave_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !$past(master_q)) |-> (ws_lvl == $past(ws_i, 2)));

    p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(master_q) && !$past(reg_wr && reg_addr == 8'h50)
         && $changed(sdata_o)) |-> $fell(sclk_o));

    p_edge_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && irq_o && !$past(word_q)) |-> $changed(ws_lvl));
endmodule

bind audio_serial_port asp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .ws_i(ws_i), .sclk_o(sclk_o), .ws_o(ws_o),
    .sdata_o(sdata_o), .irq_o(irq_o), .master_q(master_q), .ws_en_q(ws_en_q),
    .word_q(word_q), .ws_lvl(ws_lvl)
);

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic [7:0] addr = 8'h50;
    logic [15:0] wdata = '0;
    logic ws_in = 1'b0;
    logic [15:0] rdata;
    logic sclk, wso, sdo, irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    audio_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .ws_i(ws_in), .sclk_o(sclk), .ws_o(wso), .sdata_o(sdo), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int t = 0, d = 8, h = 0;
    logic [5:0] md = '0;
    logic [15:0] mL = '0, mR = '0;
    logic [31:0] cur = '0;
    logic m_ws = 0, m_sync = 0, m_irq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0; d = 8; h = 0; md = '0; mL = '0; mR = '0; cur = '0;
            m_ws = 0; m_sync = 0; m_irq = 0;
        end else begin
            bit mst, rs, nws, prev, wev;
            int bn;
            mst  = md[0];
            rs   = wr && addr == 8'h50;
            prev = m_ws;
            if (rs) begin
                t = 0; cur = {mL, mR};
            end else if (mst) begin
                t++;
                if (t % (64*(d+1)) == 0) cur = {mL, mR};
            end
            h  = (t/(d+1)) % 64;
            bn = h/2;
            nws = mst ? (bn >= 15 && bn <= 30) : m_sync;
            m_sync = ws_in;
            wev = mst ? (!rs && (t % (d+1) == 0) && (h % 32 == 0)) : (nws != prev);
            m_ws = nws;
            m_irq = (nws && !prev && md[3]) || (!nws && prev && md[4]) || (wev && md[5]);
            if (wr) begin
                case (addr)
                    8'h4C: mL = wdata;
                    8'h48: mR = wdata;
                    8'h50: d = int'(wdata[7:0]);
                    8'h54: md = wdata[5:0];
                    default: ;
                endcase
            end
        end
        #(CLK_P/4);
        begin
            logic e_sclk, e_sd, e_wso;
            logic [15:0] e_rd;
            e_sclk = md[0] && (h % 2 == 1);
            e_sd   = cur[31 - h/2];
            e_wso  = md[2] && m_ws;
            e_rd   = (addr == 8'h50) ? {14'b0, ~m_ws, m_ws} : 16'h0;
            chk(sclk == e_sclk, "R2 sclk_o", sclk, e_sclk);
            chk(sdo == e_sd, "R3 sdata_o", sdo, e_sd);
            chk(wso == e_wso, "R4 ws_o", wso, e_wso);
            chk(irq == m_irq, "R6 irq_o", irq, m_irq);
            chk(rdata == e_rd, "R10 reg_rdata", rdata, e_rd);
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr = 1'b0; addr = 8'h50;
    endtask

    task automatic count_irq(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq) cnt++;
        end
    endtask

    initial begin
        #(CLK_P*200000);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk(rdata == 16'h0002, "R1 reset status", rdata, 2);
        chk(!sclk && !wso && !irq && !sdo, "R1 reset outputs", {sclk, wso, irq, sdo}, 0);
        rst_n = 1'b1;

        // default divisor 8, master, strobe out, rising-edge interrupts
        wr_reg(8'h54, 16'h000D);
        count_irq(1200, cnt);
        chk(cnt == 2, "R6 pulses at default divisor", cnt, 2);

        // samples written mid-frame, then restart with divisor 1
        wr_reg(8'h4C, 16'hA5C3);
        wr_reg(8'h48, 16'h1234);
        wr_reg(8'h50, 16'h0001);
        chk(!sclk && !wso, "R5 restart phase", {sclk, wso}, 0);
        chk(sdo == 1'b1, "R5 reloaded MSB", sdo, 1);
        repeat (300) @(negedge clk);

        // all interrupt sources, divisor 0
        wr_reg(8'h54, 16'h003D);
        wr_reg(8'h50, 16'h0000);
        count_irq(256, cnt);
        chk(cnt == 16, "R7 rise+fall+word pulses", cnt, 16);

        // new left sample mid-frame, restart mid-frame with divisor 5
        wr_reg(8'h4C, 16'h0F0F);
        repeat (37) @(negedge clk);
        wr_reg(8'h50, 16'h0005);
        repeat (500) @(negedge clk);

        // slave mode following the external strobe
        wr_reg(8'h54, 16'h003C);
        repeat (5) @(negedge clk);
        cnt = 0;
        for (int k = 0; k < 6; k++) begin
            logic old_l;
            old_l = ws_in;
            ws_in = ~ws_in;
            @(negedge clk);
            if (irq) cnt++;
            chk(wso == old_l, "R9 strobe delay stage 1", wso, old_l);
            @(negedge clk);
            if (irq) cnt++;
            chk(wso == ~old_l, "R9 strobe delay stage 2", wso, ~old_l);
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                if (irq) cnt++;
            end
        end
        chk(cnt == 6, "R8 one pulse per coinciding edge", cnt, 6);
        chk(!sclk, "R2 sclk low in slave", sclk, 0);

        @(negedge clk);
        addr = 8'h54;
        #1;
        chk(rdata == 16'h0000, "R10 other offset reads zero", rdata, 0);
        @(negedge clk);
        addr = 8'h50;
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule